// File: doc/BRIEF.md
# Large-Page Flash Command Sequencer

This block drives the command and address phase of a large-page raw NAND flash device. A request gives an opcode, an optional column, an optional row and a few per-request options. The sequencer then plays out one bus cycle per clock on the chip-enable, command-latch, address-latch and I/O byte outputs. It adds any required second-cycle command by itself. It can also hold the bus idle for a programmable column-change settling time.

At the end of each sequence the block raises a one-cycle completion strobe. With that strobe it reports whether the caller must now wait for the device's ready/busy indication. A spare-area read is accepted as its own request code. The block turns it into a normal page read whose column is moved past the main page area. Data transfer, ECC and the ready/busy polling itself belong to other blocks.

Top module: `flashCmdSeq`

## Requirements
- R1: After reset, and while idle, ceN is 1 and cle, ale, busy, done and needWait are 0. A start pulse that arrives while busy is 1 has no effect on the sequence in progress.
- R2: The clock cycle after an accepted start is a command cycle: cle=1, ale=0, and ioOut carries the opcode. The request code 50h (spare-area read) is sent as the read opcode 00h.
- R3: For the spare-area request 50h, the column sent equals the requested column plus PAGE_BYTES (2048 by default).
- R4: When hasCol is 1, the column goes out as ALE cycles. There are two cycles, bits 7:0 first and then bits 15:8. The opcodes 90h, EEh and EFh are single-byte-address opcodes: they get one cycle. When bus16 is 1 the column is shifted right by one before it is sent, except for those three opcodes.
- R5: When hasRow is 1, the row goes out after the column as ALE cycles: bits 7:0, then bits 15:8, then bits 23:16 only if rowThree is 1.
- R6: A read (00h or 50h) that has a column or a row ends its address phase with a command cycle carrying 30h, and reports needWait=1.
- R7: A read with neither a column nor a row sends no 30h cycle and reports needWait=0.
- R8: The random-output opcode 05h is followed, after its address, by a command cycle carrying E0h. It then gets the column-change wait and reports needWait=0.
- R9: The random-input opcode 85h gets no second command. Only the column-change wait follows its address, and it reports needWait=0.
- R10: The column-change wait applies only when ccsEnable is 1. It lasts ccsCount idle cycles (busy=1, cle=ale=0). When ccsCount is 0 it lasts DEFAULT_CCS_CYCLES cycles (50 by default, 500 ns at 100 MHz).
- R11: The opcodes 10h, 15h, 60h, D0h, 80h, 70h, 90h, EFh, 05h and 85h report needWait=0. Every other opcode reports needWait=1. needWait is 1 only while done is 1.
- R12: cle and ale are never 1 together. ceN is 0 in every bus cycle. done lasts exactly one cycle and is followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept a request when idle |
| opcode | input | 8 | Command opcode or the 50h spare-read request |
| hasCol | input | 1 | Request carries a column address |
| column | input | COL_W | Column byte address |
| hasRow | input | 1 | Request carries a row (page) address |
| row | input | ROW_W | Row address |
| bus16 | input | 1 | Device uses a 16-bit data bus |
| rowThree | input | 1 | Send a third row address cycle |
| ccsEnable | input | 1 | Apply the column-change wait |
| ccsCount | input | CCS_W | Column-change wait in clocks, 0 selects the default |
| ceN | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ioOut | output | 8 | Bus byte of the current cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence strobe |
| needWait | output | 1 | With done: a ready/busy wait must follow |

## Verification
The hardest case to reach is the interaction of the spare-area rewrite with 16-bit halving. The column must first be offset by the page size and only then halved, because the request has already become a normal read. The bench gets there by sweeping every opcode against every combination of column/row presence, bus width and row-cycle count, with the column-change setting rotating through disabled, default and explicit values. It also drives a second start pulse one cycle into every sequence, so the ignore rule is exercised in all of them.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;
  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_SPARE   = 8'h50;
  localparam logic [7:0] OP_RSTART  = 8'h30;
  localparam logic [7:0] OP_RNDOUT  = 8'h05;
  localparam logic [7:0] OP_ROSTART = 8'hE0;
  localparam logic [7:0] OP_RNDIN   = 8'h85;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_COL, ST_ROW, ST_CMD2, ST_CCS, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic load;
    logic stepInc;
    logic driveCmd;
    logic driveCmd2;
    logic driveCol;
    logic driveRow;
    logic ccsRun;
  } seqStrobe_t;

  typedef struct packed {
    logic       hasCol;
    logic       hasRow;
    logic       colTwo;
    logic       rowThree;
    logic       needCmd2;
    logic       needCcs;
    logic       ccsLast;
    logic [1:0] step;
  } seqInfo_t;

  function automatic logic isByteAddrOp(input logic [7:0] op);
    return (op == 8'h90) || (op == 8'hEE) || (op == 8'hEF);
  endfunction

  function automatic logic skipsBusyWait(input logic [7:0] op);
    case (op)
      8'h10, 8'h15, 8'h60, 8'hD0, 8'h80, 8'h70, 8'h90, 8'hEF,
      OP_RNDOUT, OP_RNDIN: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqInfo_t   info,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  seqState_t state, nextState, afterAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    if (info.needCmd2)     afterAddr = ST_CMD2;
    else if (info.needCcs) afterAddr = ST_CCS;
    else                   afterAddr = ST_DONE;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_CMD;
        end
      end
      ST_CMD: begin
        strobe.driveCmd = 1'b1;
        if (info.hasCol)      nextState = ST_COL;
        else if (info.hasRow) nextState = ST_ROW;
        else                  nextState = afterAddr;
      end
      ST_COL: begin
        strobe.driveCol = 1'b1;
        if (info.colTwo && info.step == 2'd0) strobe.stepInc = 1'b1;
        else if (info.hasRow)                 nextState = ST_ROW;
        else                                  nextState = afterAddr;
      end
      ST_ROW: begin
        strobe.driveRow = 1'b1;
        if (info.step == 2'd0 || (info.rowThree && info.step == 2'd1))
          strobe.stepInc = 1'b1;
        else
          nextState = afterAddr;
      end
      ST_CMD2: begin
        strobe.driveCmd2 = 1'b1;
        nextState = info.needCcs ? ST_CCS : ST_DONE;
      end
      ST_CCS: begin
        strobe.ccsRun = 1'b1;
        if (info.ccsLast) nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/flashSeqDatapath.sv
module flashSeqDatapath
  import flashSeqPkg::*;
#(
  parameter int COL_W              = 16,
  parameter int ROW_W              = 24,
  parameter int CCS_W              = 8,
  parameter int PAGE_BYTES         = 2048,
  parameter int DEFAULT_CCS_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [7:0]       opcode,
  input  logic             hasCol,
  input  logic [COL_W-1:0] column,
  input  logic             hasRow,
  input  logic [ROW_W-1:0] row,
  input  logic             bus16,
  input  logic             rowThree,
  input  logic             ccsEnable,
  input  logic [CCS_W-1:0] ccsCount,
  output seqInfo_t         info,
  output logic [7:0]       ioOut,
  output logic             waitFlag
);
  localparam logic [COL_W-1:0] PAGE_OFS = COL_W'(PAGE_BYTES);
  localparam logic [CCS_W-1:0] CCS_DEF  = CCS_W'(DEFAULT_CCS_CYCLES);

  logic [7:0]       opReg;
  logic [COL_W-1:0] colReg;
  logic [ROW_W-1:0] rowReg;
  logic [CCS_W-1:0] ccsCnt;
  logic [1:0]       stepCnt;
  logic             hasColReg, hasRowReg, rowThreeReg, needCmd2Reg, needCcsReg;
  logic             colTwoReg, waitReg;

  logic [7:0]       opNew;
  logic [COL_W-1:0] colSum, colNew;
  logic             isSpare;

  always_comb begin
    isSpare = (opcode == OP_SPARE);
    opNew   = isSpare ? OP_READ : opcode;
    colSum  = column + (isSpare ? PAGE_OFS : '0);
    colNew  = (bus16 && !isByteAddrOp(opNew)) ? (colSum >> 1) : colSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg       <= '0;
      colReg      <= '0;
      rowReg      <= '0;
      ccsCnt      <= '0;
      hasColReg   <= 1'b0;
      hasRowReg   <= 1'b0;
      rowThreeReg <= 1'b0;
      needCmd2Reg <= 1'b0;
      needCcsReg  <= 1'b0;
      colTwoReg   <= 1'b0;
      waitReg     <= 1'b0;
    end else if (strobe.load) begin
      opReg       <= opNew;
      colReg      <= colNew;
      rowReg      <= row;
      ccsCnt      <= (ccsCount == '0) ? CCS_DEF : ccsCount;
      hasColReg   <= hasCol;
      hasRowReg   <= hasRow;
      rowThreeReg <= rowThree;
      colTwoReg   <= !isByteAddrOp(opNew);
      needCmd2Reg <= (opNew == OP_READ && (hasCol || hasRow)) || (opNew == OP_RNDOUT);
      needCcsReg  <= ccsEnable && (opNew == OP_RNDOUT || opNew == OP_RNDIN);
      waitReg     <= (opNew == OP_READ) ? (hasCol || hasRow) : !skipsBusyWait(opNew);
    end else if (strobe.ccsRun) begin
      ccsCnt <= ccsCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stepCnt <= '0;
    else if (strobe.stepInc) stepCnt <= stepCnt + 1'b1;
    else                     stepCnt <= '0;
  end

  always_comb begin
    ioOut = '0;
    if (strobe.driveCmd)       ioOut = opReg;
    else if (strobe.driveCmd2) ioOut = (opReg == OP_READ) ? OP_RSTART : OP_ROSTART;
    else if (strobe.driveCol)  ioOut = stepCnt[0] ? colReg[15:8] : colReg[7:0];
    else if (strobe.driveRow) begin
      case (stepCnt)
        2'd0:    ioOut = rowReg[7:0];
        2'd1:    ioOut = rowReg[15:8];
        default: ioOut = rowReg[23:16];
      endcase
    end
  end

  assign info.hasCol   = hasColReg;
  assign info.hasRow   = hasRowReg;
  assign info.colTwo   = colTwoReg;
  assign info.rowThree = rowThreeReg;
  assign info.needCmd2 = needCmd2Reg;
  assign info.needCcs  = needCcsReg;
  assign info.ccsLast  = (ccsCnt == CCS_W'(1));
  assign info.step     = stepCnt;
  assign waitFlag      = waitReg;
endmodule

// File: rtl/flashCmdSeq.sv
module flashCmdSeq
  import flashSeqPkg::*;
#(
  parameter int COL_W              = 16,
  parameter int ROW_W              = 24,
  parameter int CCS_W              = 8,
  parameter int PAGE_BYTES         = 2048,
  parameter int DEFAULT_CCS_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic             hasCol,
  input  logic [COL_W-1:0] column,
  input  logic             hasRow,
  input  logic [ROW_W-1:0] row,
  input  logic             bus16,
  input  logic             rowThree,
  input  logic             ccsEnable,
  input  logic [CCS_W-1:0] ccsCount,
  output logic             ceN,
  output logic             cle,
  output logic             ale,
  output logic [7:0]       ioOut,
  output logic             busy,
  output logic             done,
  output logic             needWait
);
  seqStrobe_t strobe;
  seqInfo_t   info;
  logic       waitFlag;

  flashSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .info(info),
    .strobe(strobe), .busy(busy), .done(done)
  );

  flashSeqDatapath #(
    .COL_W(COL_W), .ROW_W(ROW_W), .CCS_W(CCS_W),
    .PAGE_BYTES(PAGE_BYTES), .DEFAULT_CCS_CYCLES(DEFAULT_CCS_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opcode(opcode),
    .hasCol(hasCol), .column(column), .hasRow(hasRow), .row(row),
    .bus16(bus16), .rowThree(rowThree), .ccsEnable(ccsEnable),
    .ccsCount(ccsCount), .info(info), .ioOut(ioOut), .waitFlag(waitFlag)
  );

  assign ceN      = !busy;
  assign cle      = strobe.driveCmd | strobe.driveCmd2;
  assign ale      = strobe.driveCol | strobe.driveRow;
  assign needWait = done & waitFlag;
endmodule

// File: rtl/flashCmdSeqChecker.sv
module flashCmdSeqChecker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic ceN,
  input logic cle,
  input logic ale,
  input logic busy,
  input logic done,
  input logic needWait
);
  assert_latch_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));
  assert_ce_active_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cle || ale) |-> !ceN);
  assert_done_to_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  assert_wait_with_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    needWait |-> done);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> (!busy && ceN));
  assert_start_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (cle && !ale));
endmodule

bind flashCmdSeq flashCmdSeqChecker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .ceN(ceN), .cle(cle), .ale(ale),
  .busy(busy), .done(done), .needWait(needWait)
);

// File: tb/flashCmdSeq_tb.sv
module flashCmdSeq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic        hasCol = 1'b0, hasRow = 1'b0, bus16 = 1'b0, rowThree = 1'b0;
  logic [15:0] column = '0;
  logic [23:0] row = '0;
  logic        ccsEnable = 1'b0;
  logic [7:0]  ccsCount = '0;
  logic        ceN, cle, ale, busy, done, needWait;
  logic [7:0]  ioOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [1:0] expCtl [0:15];
  logic [7:0] expByte[0:15];
  int         expN, expCcs;
  logic       expWait;

  flashCmdSeq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .hasCol(hasCol),
    .column(column), .hasRow(hasRow), .row(row), .bus16(bus16),
    .rowThree(rowThree), .ccsEnable(ccsEnable), .ccsCount(ccsCount),
    .ceN(ceN), .cle(cle), .ale(ale), .ioOut(ioOut), .busy(busy),
    .done(done), .needWait(needWait)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (op %02h col %0d row %0d b16 %0b r3 %0b)",
               req, act, exp, opcode, hasCol, hasRow, bus16, rowThree);
    end
  endtask

  function automatic bit byteOnly(input logic [7:0] op);
    return op == 8'h90 || op == 8'hEE || op == 8'hEF;
  endfunction

  function automatic bit noWaitOp(input logic [7:0] op);
    return op == 8'h10 || op == 8'h15 || op == 8'h60 || op == 8'hD0 ||
           op == 8'h80 || op == 8'h70 || op == 8'h90 || op == 8'hEF ||
           op == 8'h05 || op == 8'h85;
  endfunction

  task automatic push(input logic [1:0] ctl, input logic [7:0] b);
    expCtl[expN]  = ctl;
    expByte[expN] = b;
    expN++;
  endtask

  // Expected bus cycles, wait length and wait flag from R2..R11.
  task automatic buildModel();
    logic [7:0]  op2;
    logic [15:0] c;
    expN = 0;
    op2 = (opcode == 8'h50) ? 8'h00 : opcode;
    c = column + ((opcode == 8'h50) ? 16'd2048 : 16'd0);
    if (bus16 && !byteOnly(op2)) c = c >> 1;
    push(2'b01, op2);
    if (hasCol) begin
      push(2'b10, c[7:0]);
      if (!byteOnly(op2)) push(2'b10, c[15:8]);
    end
    if (hasRow) begin
      push(2'b10, row[7:0]);
      push(2'b10, row[15:8]);
      if (rowThree) push(2'b10, row[23:16]);
    end
    if (op2 == 8'h00 && (hasCol || hasRow)) push(2'b01, 8'h30);
    if (op2 == 8'h05) push(2'b01, 8'hE0);
    expCcs  = ((op2 == 8'h05 || op2 == 8'h85) && ccsEnable) ?
              ((ccsCount == 0) ? 50 : int'(ccsCount)) : 0;
    expWait = (op2 == 8'h00) ? (hasCol || hasRow) : !noWaitOp(op2);
  endtask

  task automatic runSeq();
    int seen = 0;
    int ccsSeen = 0;
    int guard = 0;
    logic [7:0] savedOp;
    buildModel();
    savedOp = opcode;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cle && !ale && ioOut == expByte[0], "R2", {cle, ale, ioOut}, {2'b10, expByte[0]});
    seen = 1;
    // R1: a start pulse while busy must be ignored
    opcode = 8'hFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opcode = savedOp;
    while (!done && guard < 400) begin
      guard++;
      if (cle || ale) begin
        if (seen < expN)
          check({ale, cle} == expCtl[seen] && ioOut == expByte[seen] && !ceN,
                "R3/R4/R5/R6/R8 bus cycle", {ale, cle, ioOut},
                {expCtl[seen], expByte[seen]});
        else
          check(1'b0, "R7/R9 extra bus cycle", {ale, cle, ioOut}, 0);
        seen++;
      end else if (busy) ccsSeen++;
      @(negedge clk);
    end
    check(seen == expN, "R4/R5/R6/R7 cycle count", seen, expN);
    check(ccsSeen == expCcs, "R10 column-change wait", ccsSeen, expCcs);
    check(needWait == expWait, "R11 needWait", needWait, expWait);
    @(negedge clk);
    check(!busy && ceN && !done && !needWait, "R1/R12 back to idle",
          {busy, ceN, done, needWait}, 4'b0100);
  endtask

  initial begin
    logic [7:0] ops [0:13];
    int k = 0;
    ops = '{8'h00, 8'h50, 8'h05, 8'h85, 8'h10, 8'h15, 8'h60, 8'hD0,
            8'h80, 8'h70, 8'h90, 8'hEF, 8'hEE, 8'hFF};
    repeat (3) @(negedge clk);
    check(ceN && !cle && !ale && !busy && !done && !needWait, "R1 reset",
          {ceN, cle, ale, busy, done, needWait}, 6'b100000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(ceN && !busy, "R1 idle", {ceN, busy}, 2'b10);
    for (int o = 0; o < 14; o++) begin
      for (int m = 0; m < 16; m++) begin
        opcode    = ops[o];
        hasCol    = m[0];
        hasRow    = m[1];
        bus16     = m[2];
        rowThree  = m[3];
        column    = 16'((k * 97 + 13) % 2048);
        row       = 24'(k * 40503 + 24'h1A2B3C);
        ccsEnable = (k % 4) != 0;
        ccsCount  = ((k % 4) == 1) ? 8'd0 : 8'((k % 7) + 1);
        k++;
        runSeq();
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule